// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit privileged control registers of a processor core. Software reaches each one by a 6-bit index through a read strobe and a write strobe. A single port can carry one read and one write in the same cycle, and the two may use different indices. Reads are combinational. Writes take effect at the rising clock edge.

Each register has its own write mask and its own read and write permissions. Some registers also have side effects:
- Writing certain registers clears them, whatever the data.
- Reading the faulting-address register releases an interrupt lock.
- The cycle-count register returns a split value: its upper half comes from storage and its lower half from a live free-running counter.
- Writes to the translation-buffer control registers produce one-cycle strobes for an external translation unit. These strobes are flush all, flush process entries, flush one address, and insert an entry. A bad entry raises an error strobe instead of the insert.

Two side inputs feed the bank. A memory unit loads the faulting address, which also sets the lock. An exception unit ORs bits into the exception summary and exception mask registers. A parameter sets the number of general scratch registers, which are placed from index 0x20 upward.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, the base register (index 0x00) reads BASE_RESET and the control/status register (index 0x01) reads 0x6. Every other readable register reads zero. The interrupt lock and all strobes are low.
- R2: A write keeps only the register's own bits. The AST request (0x03) and AST enable (0x04) registers keep mask 0xF. The interrupt priority level (0x05) keeps 0x1F. The mode register (0x06) keeps 0x18. The software interrupt register (0x07) keeps 0x7FFF0.
- R3: A write to the exception return address register (0x02) stores the data with bit 1 forced to zero.
- R4: The exception summary (0x08) and exception mask (0x09) registers accumulate by OR the bits posted on the exception input. Any write to either one clears it to zero.
- R5: Reading the cycle register (0x0A) returns bits [63:32] from the last value written there. Bits [31:0] come from a counter that is zero during reset and increments on every clock edge after it.
- R6: A faulting-address load stores the address in register 0x0B and sets the interrupt lock. After an edge at which register 0x0B was read, with no load in the same cycle, the lock is low.
- R7: Register 0x0B is read-only. Registers 0x0D, 0x0E, 0x0F and 0x10 are write-only. An undefined index (0x11 to 0x1F, or a scratch index at or beyond the scratch count) is illegal in both directions. An illegal access raises the fault output in the same cycle, reads zero, and changes no state and no strobe.
- R8: A write to 0x0E pulses the flush-all strobe for the single cycle after the write edge. A write to 0x0F pulses the flush-process strobe in the same way.
- R9: A write to 0x10 pulses the flush-one strobe for one cycle, and the flush address output then carries the written value.
- R10: A write to the tag register (0x0D) pulses the insert strobe for one cycle. During that pulse the insert tag output carries the written tag and the insert entry output carries the last value written to the entry register (0x0C). If entry bits [6:5] are nonzero, the error strobe pulses instead and no insert occurs.
- R11: Each scratch register (0x20 + n) stores and returns all 64 bits.
- R12: A read of a register in the same cycle as a write to it returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 6 | Read index |
| rd_data_o | output | 64 | Read data (combinational, zero when not legal) |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 6 | Write index |
| wr_data_i | input | 64 | Write data |
| fault_o | output | 1 | Illegal read or write in this cycle |
| va_load_i | input | 1 | Load faulting address and set lock |
| va_i | input | 64 | Faulting address |
| exc_post_i | input | 1 | Post exception bits |
| exc_sum_bits_i | input | 64 | Bits ORed into exception summary |
| exc_mask_bits_i | input | 64 | Bits ORed into exception mask |
| intr_lock_o | output | 1 | Interrupt lock |
| flush_all_o | output | 1 | Flush-all strobe |
| flush_proc_o | output | 1 | Flush-process strobe |
| flush_one_o | output | 1 | Flush-one-address strobe |
| flush_va_o | output | 64 | Address for flush-one |
| tlb_insert_o | output | 1 | Insert strobe |
| ins_tag_o | output | 64 | Tag for insert |
| ins_pte_o | output | 64 | Entry for insert |
| gh_err_o | output | 1 | Entry granularity field error strobe |

## Verification
Read data and the fault output are combinational. The bench sets a read one nanosecond after a falling edge and samples it in that same half cycle, before any rising edge. A write's stored effect and every strobe appear one edge later. The write task raises the strobe at a falling edge, lowers it at the next falling edge, and checks strobes right after that, then again one cycle later to confirm they have dropped. The cycle-count check compares the live lower half with a bench counter that counts clock edges since reset. The read-during-write check samples before the shared edge and again after it.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
    localparam int IDX_W = 6;
    localparam int XLEN  = 64;
    localparam int NFIX  = 17;

    localparam logic [IDX_W-1:0] CR_BASE    = 6'h00;
    localparam logic [IDX_W-1:0] CR_CTRL    = 6'h01;
    localparam logic [IDX_W-1:0] CR_EPC     = 6'h02;
    localparam logic [IDX_W-1:0] CR_ASTREQ  = 6'h03;
    localparam logic [IDX_W-1:0] CR_ASTEN   = 6'h04;
    localparam logic [IDX_W-1:0] CR_IPL     = 6'h05;
    localparam logic [IDX_W-1:0] CR_MODE    = 6'h06;
    localparam logic [IDX_W-1:0] CR_SWINT   = 6'h07;
    localparam logic [IDX_W-1:0] CR_XSUM    = 6'h08;
    localparam logic [IDX_W-1:0] CR_XMSK    = 6'h09;
    localparam logic [IDX_W-1:0] CR_CYC     = 6'h0A;
    localparam logic [IDX_W-1:0] CR_FVA     = 6'h0B;
    localparam logic [IDX_W-1:0] CR_PTE     = 6'h0C;
    localparam logic [IDX_W-1:0] CR_TAG     = 6'h0D;
    localparam logic [IDX_W-1:0] CR_INVALL  = 6'h0E;
    localparam logic [IDX_W-1:0] CR_INVPROC = 6'h0F;
    localparam logic [IDX_W-1:0] CR_INVONE  = 6'h10;
    localparam logic [IDX_W-1:0] SCR_BASE   = 6'h20;

    // Bits a write may set in each fixed register; zero means write-to-clear.
    function automatic logic [XLEN-1:0] cr_wmask(input logic [IDX_W-1:0] idx);
        case (idx)
            CR_EPC:                         return ~64'h2;
            CR_ASTREQ, CR_ASTEN:            return 64'hF;
            CR_IPL:                         return 64'h1F;
            CR_MODE:                        return 64'h18;
            CR_SWINT:                       return 64'h7FFF0;
            CR_XSUM, CR_XMSK,
            CR_INVALL, CR_INVPROC:          return '0;
            default:                        return '1;
        endcase
    endfunction
endpackage

// File: rtl/ctlreg_decode.sv
`timescale 1ns/1ps
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int NSCR  = 8,
    parameter int SLW   = 3,
    parameter bit IS_WR = 1'b0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             ok_o,
    output logic             scr_o,
    output logic [SLW-1:0]   slot_o
);
    logic [IDX_W:0] off;
    logic           fixed_hit, rd_only, wr_only;

    always_comb begin
        off       = {1'b0, idx_i} - {1'b0, SCR_BASE};
        scr_o     = (idx_i >= SCR_BASE) && (off < (IDX_W+1)'(NSCR));
        slot_o    = off[SLW-1:0];
        fixed_hit = ({1'b0, idx_i} < (IDX_W+1)'(NFIX));
        rd_only   = (idx_i == CR_FVA);
        wr_only   = (idx_i == CR_TAG) || (idx_i == CR_INVALL) ||
                    (idx_i == CR_INVPROC) || (idx_i == CR_INVONE);
    end

    generate
        if (IS_WR) begin : g_wr
            assign ok_o = scr_o || (fixed_hit && !rd_only);
        end else begin : g_rd
            assign ok_o = scr_o || (fixed_hit && !wr_only);
        end
    endgenerate
endmodule

// File: rtl/ctlreg_cyclectr.sv
`timescale 1ns/1ps
module ctlreg_cyclectr #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/ctlreg_bank.sv
`timescale 1ns/1ps
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter int              NUM_SCRATCH = 8,
    parameter int              CNT_W       = 32,
    parameter logic [XLEN-1:0] BASE_RESET  = 64'h0000_0000_0001_0000
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_en_i,
    input  logic [5:0]      rd_idx_i,
    output logic [63:0]     rd_data_o,
    input  logic            wr_en_i,
    input  logic [5:0]      wr_idx_i,
    input  logic [63:0]     wr_data_i,
    output logic            fault_o,
    input  logic            va_load_i,
    input  logic [63:0]     va_i,
    input  logic            exc_post_i,
    input  logic [63:0]     exc_sum_bits_i,
    input  logic [63:0]     exc_mask_bits_i,
    output logic            intr_lock_o,
    output logic            flush_all_o,
    output logic            flush_proc_o,
    output logic            flush_one_o,
    output logic [63:0]     flush_va_o,
    output logic            tlb_insert_o,
    output logic [63:0]     ins_tag_o,
    output logic [63:0]     ins_pte_o,
    output logic            gh_err_o
);
    localparam int SLW = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

    typedef struct packed {
        logic [NFIX-1:0][XLEN-1:0]        fix;
        logic [NUM_SCRATCH-1:0][XLEN-1:0] scr;
        logic                             lock;
        logic                             p_all;
        logic                             p_proc;
        logic                             p_one;
        logic                             p_ins;
        logic                             p_gh;
    } st_t;

    st_t st_d, st_q;

    logic           rd_ok, rd_scr, wr_ok, wr_scr;
    logic [SLW-1:0] rd_slot, wr_slot;
    logic [CNT_W-1:0] live_cnt;
    logic           rd_go, wr_go;
    logic [XLEN-1:0] rd_raw;

    ctlreg_decode #(.NSCR(NUM_SCRATCH), .SLW(SLW), .IS_WR(1'b0)) u_rd_dec (
        .idx_i(rd_idx_i), .ok_o(rd_ok), .scr_o(rd_scr), .slot_o(rd_slot));

    ctlreg_decode #(.NSCR(NUM_SCRATCH), .SLW(SLW), .IS_WR(1'b1)) u_wr_dec (
        .idx_i(wr_idx_i), .ok_o(wr_ok), .scr_o(wr_scr), .slot_o(wr_slot));

    ctlreg_cyclectr #(.W(CNT_W)) u_cyc (
        .clk_i(clk_i), .rst_ni(rst_ni), .count_o(live_cnt));

    assign rd_go   = rd_en_i && rd_ok;
    assign wr_go   = wr_en_i && wr_ok;
    assign fault_o = (rd_en_i && !rd_ok) || (wr_en_i && !wr_ok);

    // Combinational read path with the split cycle-count view.
    always_comb begin
        rd_raw    = rd_scr ? st_q.scr[rd_slot] : st_q.fix[rd_idx_i[4:0]];
        rd_data_o = '0;
        if (rd_go) begin
            if (!rd_scr && rd_idx_i == CR_CYC)
                rd_data_o = {rd_raw[XLEN-1:CNT_W], live_cnt};
            else
                rd_data_o = rd_raw;
        end
    end

    // Next-state computation for storage, lock and strobes.
    always_comb begin
        st_d        = st_q;
        st_d.p_all  = 1'b0;
        st_d.p_proc = 1'b0;
        st_d.p_one  = 1'b0;
        st_d.p_ins  = 1'b0;
        st_d.p_gh   = 1'b0;

        if (wr_go) begin
            if (wr_scr) begin
                st_d.scr[wr_slot] = wr_data_i;
            end else begin
                st_d.fix[wr_idx_i[4:0]] = wr_data_i & cr_wmask(wr_idx_i);
                case (wr_idx_i)
                    CR_INVALL:  st_d.p_all  = 1'b1;
                    CR_INVPROC: st_d.p_proc = 1'b1;
                    CR_INVONE:  st_d.p_one  = 1'b1;
                    CR_TAG: begin
                        if (st_q.fix[CR_PTE][6:5] != 2'b00) st_d.p_gh  = 1'b1;
                        else                                st_d.p_ins = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        if (exc_post_i) begin
            st_d.fix[CR_XSUM] = st_d.fix[CR_XSUM] | exc_sum_bits_i;
            st_d.fix[CR_XMSK] = st_d.fix[CR_XMSK] | exc_mask_bits_i;
        end

        if (rd_go && !rd_scr && rd_idx_i == CR_FVA) st_d.lock = 1'b0;
        if (va_load_i) begin
            st_d.fix[CR_FVA] = va_i;
            st_d.lock        = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q              <= '0;
            st_q.fix[CR_BASE] <= BASE_RESET;
            st_q.fix[CR_CTRL] <= 64'h6;
        end else begin
            st_q <= st_d;
        end
    end

    assign intr_lock_o  = st_q.lock;
    assign flush_all_o  = st_q.p_all;
    assign flush_proc_o = st_q.p_proc;
    assign flush_one_o  = st_q.p_one;
    assign flush_va_o   = st_q.fix[CR_INVONE];
    assign tlb_insert_o = st_q.p_ins;
    assign ins_tag_o    = st_q.fix[CR_TAG];
    assign ins_pte_o    = st_q.fix[CR_PTE];
    assign gh_err_o     = st_q.p_gh;
endmodule

// File: rtl/ctlreg_bank_chk.sv
`timescale 1ns/1ps
module ctlreg_bank_chk
    import ctlreg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rd_en_i,
    input logic [5:0]  rd_idx_i,
    input logic [63:0] rd_data_o,
    input logic        wr_en_i,
    input logic [5:0]  wr_idx_i,
    input logic        fault_o,
    input logic        va_load_i,
    input logic        intr_lock_o,
    input logic        flush_all_o,
    input logic        flush_proc_o,
    input logic        flush_one_o,
    input logic        tlb_insert_o,
    input logic [63:0] ins_pte_o,
    input logic        gh_err_o
);
    a_r5_live_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_idx_i == CR_CYC && $past(rd_en_i && rd_idx_i == CR_CYC))
        |-> rd_data_o[CNT_W-1:0] == $past(rd_data_o[CNT_W-1:0]) + CNT_W'(1));

    a_r6_load_sets_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        va_load_i |=> intr_lock_o);

    a_r6_read_clears_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_idx_i == CR_FVA && !va_load_i) |=> !intr_lock_o);

    a_r7_write_only_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_idx_i == CR_TAG) |-> (fault_o && rd_data_o == '0));

    a_r7_fault_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rd_en_i && fault_o)
        |=> !(flush_all_o || flush_proc_o || flush_one_o || tlb_insert_o || gh_err_o));

    a_r8_flush_all_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_all_o |-> $past(wr_en_i && wr_idx_i == CR_INVALL));

    a_r8_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({flush_all_o, flush_proc_o, flush_one_o, tlb_insert_o, gh_err_o}));

    a_r10_insert_clean_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_insert_o |-> ($past(wr_en_i && wr_idx_i == CR_TAG) && ins_pte_o[6:5] == 2'b00));
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .fault_o(fault_o), .va_load_i(va_load_i), .intr_lock_o(intr_lock_o),
    .flush_all_o(flush_all_o), .flush_proc_o(flush_proc_o),
    .flush_one_o(flush_one_o), .tlb_insert_o(tlb_insert_o),
    .ins_pte_o(ins_pte_o), .gh_err_o(gh_err_o));

// File: tb/ctlreg_bank_test.sv
`timescale 1ns/1ps
module ctlreg_bank_test;
    localparam int          NSCR  = 8;
    localparam logic [63:0] BASEV = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [5:0]  rd_idx = '0, wr_idx = '0;
    logic [63:0] wr_data = '0, rd_data;
    logic        fault;
    logic        va_load = 1'b0, exc_post = 1'b0;
    logic [63:0] va = '0, exc_sum = '0, exc_msk = '0;
    logic        lock, f_all, f_proc, f_one, ins, gh;
    logic [63:0] f_va, ins_tag, ins_pte;

    int          n_checks = 0, n_errors = 0;
    int unsigned tb_cyc = 0;
    logic [63:0] v;
    logic        flt;

    ctlreg_bank #(.NUM_SCRATCH(NSCR), .CNT_W(32), .BASE_RESET(BASEV)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .fault_o(fault), .va_load_i(va_load), .va_i(va),
        .exc_post_i(exc_post), .exc_sum_bits_i(exc_sum), .exc_mask_bits_i(exc_msk),
        .intr_lock_o(lock), .flush_all_o(f_all), .flush_proc_o(f_proc),
        .flush_one_o(f_one), .flush_va_o(f_va), .tlb_insert_o(ins),
        .ins_tag_o(ins_tag), .ins_pte_o(ins_pte), .gh_err_o(gh));

    always #10 clk = ~clk;
    always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic do_rd(input logic [5:0] idx, output logic [63:0] d, output logic f);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        #1;
        d = rd_data; f = fault;
        rd_en = 1'b0;
    endtask

    task automatic strobes_low(input string tag);
        chk(tag, {59'd0, f_all, f_proc, f_one, ins, gh}, 64'd0);
    endtask

    task automatic t_reset;
        do_rd(6'h00, v, flt); chk("R1 base", v, BASEV);
        do_rd(6'h01, v, flt); chk("R1 ctrl", v, 64'h6);
        do_rd(6'h05, v, flt); chk("R1 ipl", v, 64'h0);
        do_rd(6'h20, v, flt); chk("R1 scratch0", v, 64'h0);
        chk("R1 lock", {63'd0, lock}, 64'd0);
        strobes_low("R1 strobes");
    endtask

    task automatic t_masks;
        do_wr(6'h03, '1); do_rd(6'h03, v, flt); chk("R2 astreq", v, 64'hF);
        do_wr(6'h04, '1); do_rd(6'h04, v, flt); chk("R2 asten", v, 64'hF);
        do_wr(6'h05, '1); do_rd(6'h05, v, flt); chk("R2 ipl", v, 64'h1F);
        do_wr(6'h06, '1); do_rd(6'h06, v, flt); chk("R2 mode", v, 64'h18);
        do_wr(6'h07, '1); do_rd(6'h07, v, flt); chk("R2 swint", v, 64'h7FFF0);
        do_wr(6'h05, 64'hFFFF_FFFF_FFFF_FFEA); do_rd(6'h05, v, flt); chk("R2 ipl pattern", v, 64'h0A);
    endtask

    task automatic t_epc;
        do_wr(6'h02, 64'h8000_0000_1234_5677); do_rd(6'h02, v, flt);
        chk("R3 epc bit1", v, 64'h8000_0000_1234_5675);
        do_wr(6'h02, 64'h0000_0000_0000_0001); do_rd(6'h02, v, flt);
        chk("R3 epc bit0 kept", v, 64'h1);
    endtask

    task automatic t_wclr;
        @(negedge clk);
        exc_post = 1'b1; exc_sum = 64'hA5; exc_msk = 64'h3C00;
        @(negedge clk); exc_post = 1'b0;
        do_rd(6'h08, v, flt); chk("R4 sum posted", v, 64'hA5);
        do_rd(6'h09, v, flt); chk("R4 mask posted", v, 64'h3C00);
        do_wr(6'h08, '1); do_rd(6'h08, v, flt); chk("R4 sum cleared", v, 64'h0);
        do_wr(6'h09, 64'h1234); do_rd(6'h09, v, flt); chk("R4 mask cleared", v, 64'h0);
    endtask

    task automatic t_cyc;
        do_wr(6'h0A, 64'hDEAD_BEEF_0000_1111);
        do_rd(6'h0A, v, flt);
        chk("R5 upper", {32'd0, v[63:32]}, 64'hDEAD_BEEF);
        chk("R5 live lower", {32'd0, v[31:0]}, {32'd0, tb_cyc});
        repeat (7) @(negedge clk);
        do_rd(6'h0A, v, flt);
        chk("R5 live later", {32'd0, v[31:0]}, {32'd0, tb_cyc});
    endtask

    task automatic t_lock;
        @(negedge clk); va_load = 1'b1; va = 64'hFFFF_0000_ABCD_0040;
        @(negedge clk); va_load = 1'b0; #1;
        chk("R6 lock set", {63'd0, lock}, 64'd1);
        rd_en = 1'b1; rd_idx = 6'h0B; #1;
        chk("R6 va value", rd_data, 64'hFFFF_0000_ABCD_0040);
        chk("R6 lock held during read", {63'd0, lock}, 64'd1);
        @(negedge clk); rd_en = 1'b0; #1;
        chk("R6 lock cleared", {63'd0, lock}, 64'd0);
    endtask

    task automatic t_faults;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'h0B; wr_data = 64'h55; #1;
        chk("R7 write ro fault", {63'd0, fault}, 64'd1);
        @(negedge clk); wr_en = 1'b0; #1;
        strobes_low("R7 no strobe");
        do_rd(6'h0B, v, flt); chk("R7 ro unchanged", v, 64'hFFFF_0000_ABCD_0040);
        do_rd(6'h0D, v, flt); chk("R7 read wo fault", {63'd0, flt}, 64'd1);
        chk("R7 read wo zero", v, 64'd0);
        do_rd(6'h11, v, flt); chk("R7 undefined read", {63'd0, flt}, 64'd1);
        do_rd(6'(32 + NSCR), v, flt); chk("R7 scratch beyond", {63'd0, flt}, 64'd1);
        do_rd(6'h00, v, flt); chk("R7 legal no fault", {63'd0, flt}, 64'd0);
        @(negedge clk); wr_en = 1'b1; wr_idx = 6'h1F; wr_data = '1; #1;
        chk("R7 undefined write", {63'd0, fault}, 64'd1);
        @(negedge clk); wr_en = 1'b0;
        do_rd(6'h00, v, flt); chk("R7 base intact", v, BASEV);
    endtask

    task automatic t_flush;
        do_wr(6'h0E, 64'h77);
        chk("R8 flush all", {63'd0, f_all}, 64'd1);
        chk("R8 others low", {61'd0, f_proc, f_one, ins}, 64'd0);
        @(negedge clk); #1; chk("R8 flush all one cycle", {63'd0, f_all}, 64'd0);
        do_wr(6'h0F, 64'h1);
        chk("R8 flush proc", {63'd0, f_proc}, 64'd1);
        @(negedge clk); #1; chk("R8 flush proc one cycle", {63'd0, f_proc}, 64'd0);
        do_wr(6'h10, 64'h0000_7FFF_0000_2000);
        chk("R9 flush one", {63'd0, f_one}, 64'd1);
        chk("R9 flush addr", f_va, 64'h0000_7FFF_0000_2000);
        @(negedge clk); #1; chk("R9 flush one dropped", {63'd0, f_one}, 64'd0);
    endtask

    task automatic t_insert;
        do_wr(6'h0C, 64'h0123_4567_0000_0F12);
        do_wr(6'h0D, 64'h0000_0000_4000_E000);
        chk("R10 insert", {63'd0, ins}, 64'd1);
        chk("R10 tag", ins_tag, 64'h0000_0000_4000_E000);
        chk("R10 entry", ins_pte, 64'h0123_4567_0000_0F12);
        chk("R10 no error", {63'd0, gh}, 64'd0);
        @(negedge clk); #1; chk("R10 insert dropped", {63'd0, ins}, 64'd0);
        do_wr(6'h0C, 64'h0000_0000_0000_0020);
        do_wr(6'h0D, 64'h1000);
        chk("R10 gh error", {63'd0, gh}, 64'd1);
        chk("R10 gh suppresses insert", {63'd0, ins}, 64'd0);
    endtask

    task automatic t_scratch;
        for (int i = 0; i < NSCR; i++)
            do_wr(6'(32 + i), {32'hC0DE_0000 + 32'(i), 32'hFFFF_FFFF - 32'(i)});
        for (int i = 0; i < NSCR; i++) begin
            do_rd(6'(32 + i), v, flt);
            chk("R11 scratch", v, {32'hC0DE_0000 + 32'(i), 32'hFFFF_FFFF - 32'(i)});
        end
    endtask

    task automatic t_rdw;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'h21; wr_data = 64'h1111_2222_3333_4444;
        rd_en = 1'b1; rd_idx = 6'h21; #1;
        chk("R12 old value", rd_data, {32'hC0DE_0001, 32'hFFFF_FFFE});
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R12 new value", rd_data, 64'h1111_2222_3333_4444);
        rd_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_epc();
        t_wclr();
        t_cyc();
        t_lock();
        t_faults();
        t_flush();
        t_insert();
        t_scratch();
        t_rdw();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule